// File: doc/BRIEF.md
# Single-Wire Slave Mode Controller

This block sequences the operating mode of the slave end of a self-clocked, single-wire serial memory bus. It sits behind a bit-level receiver that has already turned line activity into one-cycle event strobes. It decides whether the device is asleep, taking part in a command, or deaf to the bus. While a command is in progress it checks the device address byte and the command byte. It also tracks the acknowledge bit that follows every byte.

Each byte is followed by one acknowledge bit from the master, then one acknowledge bit from the slave. A master acknowledge means more bytes follow. A master no-acknowledge ends the command: the slave answers once and returns to low-power standby. If that command was one that writes, and the write-enable latch is set, a write-cycle start pulse is issued. Protocol violations and lost synchronisation send the block to idle. Only a standby pulse brings it out of idle.

Top module: `swire_mode_ctrl`

## Requirements
- R1: After reset the mode output reads standby (code 0), and the slave-acknowledge and write-start pulses are low.
- R2: In standby, a falling-edge event moves the mode to active (code 1) on the next clock, ready to take an address byte.
- R3: A standby pulse returns the mode to standby from any mode on the next clock, with no acknowledge or write-start pulse.
- R4: In idle (code 2), every event except a standby pulse is ignored: the mode stays idle and no pulse is produced.
- R5: A missed-edge event while active forces idle.
- R6: The first byte of a command must equal the parameter DEV_ADDR (default 8'hA0). On a mismatch the mode goes to idle; on a match the block waits for the acknowledge bit.
- R7: The second byte is a command byte. Bits [7:3] must equal the parameter CMD_TAG (default 5'b10110), and bits [2:0] give the code: 0 read, 1 status read, 2 write, 3 status write, 4 write enable, 5 write disable, 6 fill-all, 7 clear-all. Any other tag forces idle.
- R8: While busy is high, codes 0, 1, 2, 3, 6 and 7 force idle. Codes 4 and 5 are still accepted.
- R9: A master acknowledge after the command byte of codes 4, 5, 6 or 7 forces idle.
- R10: A master acknowledge after a data byte of a status-write command (code 3) forces idle.
- R11: A master no-acknowledge gives a write-start pulse one clock wide, together with the slave-acknowledge pulse, when write-enable is high and either of these holds: the command byte was code 6 or 7, or a data byte of code 2 or 3 has just been received.
- R12: No write-start pulse is produced while the write-enable input is low, whatever the command.
- R13: A master no-acknowledge in the acknowledge slot ends the command. On the next clock the slave-acknowledge pulse is high for one clock and the mode is standby.
- R14: A master acknowledge that is legal produces a one-clock slave-acknowledge pulse. The mode stays active and the block moves from address to command to data bytes, staying in data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_fall_i | input | 1 | Line falling edge seen (strobe) |
| ev_stby_i | input | 1 | Standby pulse seen (strobe) |
| ev_byte_i | input | 1 | A byte has been received (strobe) |
| byte_i | input | 8 | Value of the received byte, valid with ev_byte_i |
| ev_mak_i | input | 1 | Master acknowledge bit received (strobe) |
| ev_nomak_i | input | 1 | Master no-acknowledge bit received (strobe) |
| ev_miss_i | input | 1 | Receiver missed an expected edge (strobe) |
| busy_i | input | 1 | A write cycle is in progress |
| wel_i | input | 1 | Write-enable latch state |
| mode_o | output | 2 | 0 standby, 1 active, 2 idle |
| sak_go_o | output | 1 | Drive the slave acknowledge bit now (one clock) |
| wr_start_o | output | 1 | Start a write cycle (one clock) |

## Verification
The assertions assume that the receiver raises at most one of its event strobes in a given clock. They also assume that the acknowledge strobes follow the protocol: a master acknowledge or no-acknowledge comes only after a byte. Strobes that arrive out of turn are harmless, but the properties that name a single event guard against a standby pulse arriving in the same clock. The random stimulus drives exactly one event per step. It mostly follows the protocol, with correct addresses and tags, and mixes in stray standby pulses, missed edges and out-of-place events. Busy and write-enable are redrawn on every step, so blocked commands and suppressed writes both occur.

// File: rtl/swm_pkg.sv
package swm_pkg;
  typedef enum logic [1:0] {M_STBY = 2'd0, M_ACT = 2'd1, M_IDLE = 2'd2} mode_e;
  typedef enum logic [1:0] {S_ADDR = 2'd0, S_CMD = 2'd1, S_DATA = 2'd2} stage_e;
  typedef enum logic [2:0] {
    C_READ = 3'd0, C_SREAD = 3'd1, C_WRITE = 3'd2, C_SWRITE = 3'd3,
    C_WEN = 3'd4, C_WDIS = 3'd5, C_FILL = 3'd6, C_CLEAR = 3'd7
  } cmd_e;

  // Commands refused while a write cycle runs
  function automatic logic busy_refused(input logic [2:0] c);
    return !(c == C_WEN || c == C_WDIS);
  endfunction

  // Master acknowledge is illegal in this slot
  function automatic logic mak_illegal(input stage_e s, input logic [2:0] c);
    return (s == S_CMD && (c == C_WEN || c == C_WDIS || c == C_FILL || c == C_CLEAR)) ||
           (s == S_DATA && c == C_SWRITE);
  endfunction

  // A no-acknowledge in this slot launches a write cycle
  function automatic logic ends_in_write(input stage_e s, input logic [2:0] c);
    return (s == S_CMD && (c == C_FILL || c == C_CLEAR)) ||
           (s == S_DATA && (c == C_WRITE || c == C_SWRITE));
  endfunction

  function automatic stage_e stage_after(input stage_e s);
    return (s == S_ADDR) ? S_CMD : S_DATA;
  endfunction
endpackage

// File: rtl/swm_byte_check.sv
module swm_byte_check
  import swm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hA0,
  parameter logic [BYTE_W-$bits(cmd_e)-1:0] CMD_TAG = 5'b10110
) (
  input  logic [BYTE_W-1:0]        byte_i,
  input  logic                     busy_i,
  output logic                     addr_ok_o,
  output logic                     cmd_known_o,
  output logic                     cmd_blocked_o,
  output logic [$bits(cmd_e)-1:0]  code_o
);
  localparam int CODE_W = $bits(cmd_e);

  assign addr_ok_o     = (byte_i == DEV_ADDR);
  assign code_o        = byte_i[CODE_W-1:0];
  assign cmd_known_o   = (byte_i[BYTE_W-1:CODE_W] == CMD_TAG);
  assign cmd_blocked_o = cmd_known_o && busy_i && busy_refused(code_o);
endmodule

// File: rtl/swm_ack_rules.sv
module swm_ack_rules
  import swm_pkg::*;
(
  input  stage_e                   stage_i,
  input  logic [$bits(cmd_e)-1:0]  cmd_i,
  output logic                     mak_kill_o,
  output logic                     write_end_o,
  output stage_e                   next_stage_o
);
  assign mak_kill_o   = mak_illegal(stage_i, cmd_i);
  assign write_end_o  = ends_in_write(stage_i, cmd_i);
  assign next_stage_o = stage_after(stage_i);
endmodule

// File: rtl/swire_mode_ctrl.sv
module swire_mode_ctrl
  import swm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hA0,
  parameter logic [BYTE_W-$bits(cmd_e)-1:0] CMD_TAG = 5'b10110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fall_i,
  input  logic              ev_stby_i,
  input  logic              ev_byte_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ev_mak_i,
  input  logic              ev_nomak_i,
  input  logic              ev_miss_i,
  input  logic              busy_i,
  input  logic              wel_i,
  output logic [1:0]        mode_o,
  output logic              sak_go_o,
  output logic              wr_start_o
);
  localparam int CODE_W = $bits(cmd_e);

  mode_e             mode_q, mode_d;
  stage_e            stage_q, stage_d;
  logic              await_q, await_d;
  logic [CODE_W-1:0] cmd_q, cmd_d;
  logic              sak_q, sak_d, wr_q, wr_d;

  logic              addr_ok, cmd_known, cmd_blocked;
  logic [CODE_W-1:0] code;
  logic              mak_kill, write_end;
  stage_e            next_stage;

  swm_byte_check #(.BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR), .CMD_TAG(CMD_TAG)) u_check (
    .byte_i(byte_i), .busy_i(busy_i), .addr_ok_o(addr_ok), .cmd_known_o(cmd_known),
    .cmd_blocked_o(cmd_blocked), .code_o(code)
  );

  swm_ack_rules u_ack (
    .stage_i(stage_q), .cmd_i(cmd_q), .mak_kill_o(mak_kill),
    .write_end_o(write_end), .next_stage_o(next_stage)
  );

  // Named events for the assertions
  logic active, byte_ev, mak_ev, nomak_ev;
  logic addr_bad, cmd_unknown, cmd_refused, reject;
  assign active      = (mode_q == M_ACT) && !ev_stby_i && !ev_miss_i;
  assign byte_ev     = active && !await_q && ev_byte_i;
  assign mak_ev      = active && await_q && ev_mak_i;
  assign nomak_ev    = active && await_q && !ev_mak_i && ev_nomak_i;
  assign addr_bad    = byte_ev && (stage_q == S_ADDR) && !addr_ok;
  assign cmd_unknown = byte_ev && (stage_q == S_CMD) && !cmd_known;
  assign cmd_refused = byte_ev && (stage_q == S_CMD) && cmd_blocked;
  assign reject      = addr_bad || cmd_unknown || cmd_refused;

  always_comb begin
    mode_d  = mode_q;
    stage_d = stage_q;
    await_d = await_q;
    cmd_d   = cmd_q;
    sak_d   = 1'b0;
    wr_d    = 1'b0;
    if (ev_stby_i) begin
      mode_d  = M_STBY;
      stage_d = S_ADDR;
      await_d = 1'b0;
    end else begin
      case (mode_q)
        M_STBY: if (ev_fall_i) begin
          mode_d  = M_ACT;
          stage_d = S_ADDR;
          await_d = 1'b0;
        end
        M_ACT: begin
          if (ev_miss_i) begin
            mode_d = M_IDLE;
          end else if (byte_ev) begin
            if (reject) begin
              mode_d = M_IDLE;
            end else begin
              await_d = 1'b1;
              if (stage_q == S_CMD) cmd_d = code;
            end
          end else if (mak_ev) begin
            if (mak_kill) begin
              mode_d = M_IDLE;
            end else begin
              sak_d   = 1'b1;
              await_d = 1'b0;
              stage_d = next_stage;
            end
          end else if (nomak_ev) begin
            sak_d   = 1'b1;
            wr_d    = write_end && wel_i;
            mode_d  = M_STBY;
            stage_d = S_ADDR;
            await_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_STBY;
      stage_q <= S_ADDR;
      await_q <= 1'b0;
      cmd_q   <= '0;
      sak_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      stage_q <= stage_d;
      await_q <= await_d;
      cmd_q   <= cmd_d;
      sak_q   <= sak_d;
      wr_q    <= wr_d;
    end
  end

  assign mode_o     = mode_q;
  assign sak_go_o   = sak_q;
  assign wr_start_o = wr_q;

  // Assertions
  assert_fall_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY && ev_fall_i && !ev_stby_i) |=> (mode_q == M_ACT));
  assert_stby_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stby_i |=> (mode_q == M_STBY && !sak_go_o && !wr_start_o));
  assert_idle_deaf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IDLE && !ev_stby_i) |=> (mode_q == M_IDLE && !sak_go_o && !wr_start_o));
  assert_miss_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ACT && ev_miss_i && !ev_stby_i) |=> (mode_q == M_IDLE));
  assert_addr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |=> (mode_q == M_IDLE));
  assert_cmd_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unknown |=> (mode_q == M_IDLE));
  assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refused |=> (mode_q == M_IDLE));
  assert_mak_cmd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mak_ev && stage_q == S_CMD && mak_kill) |=> (mode_q == M_IDLE && !sak_go_o));
  assert_mak_sdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mak_ev && stage_q == S_DATA && cmd_q == C_SWRITE) |=> (mode_q == M_IDLE));
  assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |=> !wr_start_o);
  assert_wr_with_sak_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> (sak_go_o && mode_q == M_STBY));
  assert_wr_needs_wel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(wel_i));
  assert_nomak_ends_R13: assert property (@(posedge clk) disable iff (!rst_n)
    nomak_ev |=> (sak_go_o && mode_q == M_STBY));
  assert_sak_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sak_go_o |=> !sak_go_o);
  assert_mak_advances_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mak_ev && !mak_kill) |=> (sak_go_o && mode_q == M_ACT));
endmodule

// File: tb/swire_mode_ctrl_bench.sv
module swire_mode_ctrl_bench;
  localparam logic [7:0] ADDR = 8'hA0;
  localparam logic [4:0] TAG  = 5'b10110;
  localparam int K_NONE = 0, K_FALL = 1, K_STBY = 2, K_BYTE = 3, K_MAK = 4, K_NOMAK = 5, K_MISS = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_fall = 0, ev_stby = 0, ev_byte = 0, ev_mak = 0, ev_nomak = 0, ev_miss = 0;
  logic [7:0] byte_v = 8'h00;
  logic busy = 0, wel = 0;
  logic [1:0] mode;
  logic sak, wrs;

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference state, kept in the bench's own terms
  int ref_mode = 0;   // 0 standby, 1 active, 2 idle
  int ref_pos = 0;    // 0 address, 1 command, 2 data
  bit ref_wait = 0;   // expecting an acknowledge bit
  int ref_code = 0;
  bit x_sak, x_wr;

  always #10 clk = ~clk;

  swire_mode_ctrl u_swire_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_fall_i(ev_fall), .ev_stby_i(ev_stby), .ev_byte_i(ev_byte),
    .byte_i(byte_v), .ev_mak_i(ev_mak), .ev_nomak_i(ev_nomak), .ev_miss_i(ev_miss),
    .busy_i(busy), .wel_i(wel), .mode_o(mode), .sak_go_o(sak), .wr_start_o(wrs)
  );

  function automatic bit is_cfg_cmd(int c);  return c >= 4; endfunction
  function automatic bit refused_busy(int c); return !(c == 4 || c == 5); endfunction
  function automatic bit mem_write(int c);   return c == 2 || c == 3; endfunction
  function automatic bit bulk_write(int c);  return c == 6 || c == 7; endfunction

  task automatic predict(input int k, input logic [7:0] d, output string tag);
    x_sak = 0; x_wr = 0; tag = "R4";
    if (k == K_STBY) begin
      ref_mode = 0; ref_pos = 0; ref_wait = 0; tag = "R3";
    end else if (ref_mode == 0) begin
      tag = "R2";
      if (k == K_FALL) begin ref_mode = 1; ref_pos = 0; ref_wait = 0; end
    end else if (ref_mode == 1) begin
      tag = "R14";
      if (k == K_MISS) begin
        ref_mode = 2; tag = "R5";
      end else if (k == K_BYTE && !ref_wait) begin
        if (ref_pos == 0) begin
          tag = "R6";
          if (d != ADDR) ref_mode = 2; else ref_wait = 1;
        end else if (ref_pos == 1) begin
          if (d[7:3] != TAG) begin ref_mode = 2; tag = "R7"; end
          else if (busy && refused_busy(int'(d[2:0]))) begin ref_mode = 2; tag = "R8"; end
          else begin ref_code = int'(d[2:0]); ref_wait = 1; tag = "R8"; end
        end else ref_wait = 1;
      end else if (k == K_MAK && ref_wait) begin
        if (ref_pos == 1 && is_cfg_cmd(ref_code)) begin ref_mode = 2; tag = "R9"; end
        else if (ref_pos == 2 && ref_code == 3) begin ref_mode = 2; tag = "R10"; end
        else begin x_sak = 1; ref_wait = 0; if (ref_pos < 2) ref_pos++; end
      end else if (k == K_NOMAK && ref_wait) begin
        bit wc;
        wc = (ref_pos == 1 && bulk_write(ref_code)) || (ref_pos == 2 && mem_write(ref_code));
        x_sak = 1; x_wr = wc && wel;
        tag = wc ? (wel ? "R11" : "R12") : "R13";
        ref_mode = 0; ref_pos = 0; ref_wait = 0;
      end
    end
  endtask

  task automatic check(input string tag, input logic [1:0] m, input bit s, input bit w);
    tests++;
    if (mode !== m || sak !== s || wrs !== w) begin
      fails++;
      $display("FAIL %s: mode/sak/wr = %0d/%0b/%0b expected %0d/%0b/%0b", tag, mode, sak, wrs, m, s, w);
    end
  endtask

  // Called at a falling edge: drive one event, then check at the next falling edge
  task automatic step(input int k, input logic [7:0] d);
    string tag;
    ev_fall = (k == K_FALL); ev_stby = (k == K_STBY); ev_byte = (k == K_BYTE);
    ev_mak = (k == K_MAK); ev_nomak = (k == K_NOMAK); ev_miss = (k == K_MISS);
    byte_v = d;
    predict(k, d, tag);
    @(negedge clk);
    ev_fall = 0; ev_stby = 0; ev_byte = 0; ev_mak = 0; ev_nomak = 0; ev_miss = 0;
    check(tag, 2'(ref_mode), x_sak, x_wr);
  endtask

  task automatic open_cmd(input int c);
    step(K_FALL, 8'h00); step(K_BYTE, ADDR); step(K_MAK, 8'h00);
    step(K_BYTE, {TAG, 3'(c)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5813);
    repeat (3) @(negedge clk);
    check("R1", 2'd0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'd0, 0, 0);

    // Directed: memory write with two data bytes, enabled
    wel = 1; busy = 0;
    open_cmd(2); step(K_MAK, 0); step(K_BYTE, 8'h5A); step(K_MAK, 0);
    step(K_BYTE, 8'h3C); step(K_NOMAK, 0);                 // R11
    // Status write: acknowledge after data goes idle, idle ignores traffic
    open_cmd(3); step(K_MAK, 0); step(K_BYTE, 8'h01); step(K_MAK, 0);   // R10
    step(K_FALL, 0); step(K_BYTE, ADDR); step(K_NOMAK, 0);  // R4
    step(K_STBY, 0);
    // Write enable followed by an acknowledge is illegal
    open_cmd(4); step(K_MAK, 0); step(K_STBY, 0);           // R9
    // Busy: read refused, write enable still accepted
    busy = 1; open_cmd(0); step(K_STBY, 0);                 // R8
    open_cmd(4); step(K_NOMAK, 0); busy = 0;                // R8, R13
    // Fill-all with the latch clear gives no write
    wel = 0; open_cmd(6); step(K_NOMAK, 0);                 // R12
    wel = 1; open_cmd(7); step(K_NOMAK, 0);                 // R11
    // Wrong address, unknown tag, missed edge
    step(K_FALL, 0); step(K_BYTE, 8'hA1); step(K_STBY, 0);  // R6
    step(K_FALL, 0); step(K_BYTE, ADDR); step(K_MAK, 0); step(K_BYTE, 8'h12); step(K_STBY, 0); // R7
    step(K_FALL, 0); step(K_BYTE, ADDR); step(K_MISS, 0); step(K_STBY, 0); // R5
    // Address then no-acknowledge is a clean end
    step(K_FALL, 0); step(K_BYTE, ADDR); step(K_NOMAK, 0);  // R13

    // Constrained random
    for (int i = 0; i < 5000; i++) begin
      int r, k;
      logic [7:0] d;
      r = int'($urandom_range(99));
      busy = ($urandom_range(3) == 0);
      wel  = ($urandom_range(9) < 6);
      if (r < 3) k = K_STBY;
      else if (r < 5) k = K_MISS;
      else if (ref_mode == 0) k = (r < 75) ? K_FALL : K_BYTE;
      else if (ref_mode == 2) k = 1 + int'($urandom_range(4)) + (r < 50 ? 0 : 0);
      else if (ref_wait) k = (r < 70) ? K_MAK : K_NOMAK;
      else k = (r < 95) ? K_BYTE : K_MAK;
      if (k == K_STBY && ref_mode == 2 && r >= 3) k = K_STBY;
      d = 8'($urandom);
      if (ref_pos == 0 && $urandom_range(99) < 85) d = ADDR;
      else if (ref_pos == 1 && $urandom_range(99) < 88) d = {TAG, 3'($urandom)};
      if (ref_mode == 2 && r > 90) k = K_STBY;
      step(k, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule